// File: doc/BRIEF.md
# Two-Level Page Translator with Translation Cache

This block turns a 32-bit linear address into a 32-bit physical address. The upper twenty bits of the linear address name a virtual page. The lower twelve bits are the offset inside a 4 KB page, and they pass through unchanged. A fully associative cache of recent translations is searched first. On a hit the answer comes back in the next cycle.

On a miss, the block walks two tables in memory over a simple 32-bit read port. Bits 31:22 of the linear address index a page directory of 1024 four-byte entries. The directory's frame comes from a base register input. The directory entry that is read gives the frame of a page table. Bits 21:12 index that table, which also has 1024 four-byte entries. The table entry that is read gives the physical frame. The new translation is written into the cache, replacing the least recently used entry once the cache is full, and the result is returned.

A flush input empties the whole cache. Only one translation is in flight at a time. A request that arrives while a walk is running is dropped.

Top module: `pgx_top`

## Requirements
- R1: The first memory read of a walk goes to address {dir_base[31:12], 12'h000} + 4 * laddr[31:22]; the low 12 bits of dir_base are ignored.
- R2: The second read of a walk goes to {D[31:12], 12'h000} + 4 * laddr[21:12], where D is the word returned by the first read; the low 12 bits of D are ignored.
- R3: The translated address is {T[31:12], laddr[11:0]}, where T is the word returned by the table read; the low 12 bits of T are ignored.
- R4: A request whose page is cached raises done, with the correct address, exactly one cycle after the request, and makes no memory read.
- R5: A request whose page is not cached makes exactly two memory reads, directory first and table second. Done follows the cycle after the second read completes, and done is never high while a read is pending.
- R6: The read request stays high with a stable address until mem_rd_valid is seen with it. That cycle completes the read.
- R7: The cache holds TLB_ENTRIES translations. Empty slots are filled before any eviction. When the cache is full, the least recently used entry is replaced, and both hits and fills count as uses.
- R8: Flush invalidates every entry. A request in the same cycle as flush is treated as a miss, and a fill in the same cycle as flush is not kept.
- R9: A request made while a walk is running is ignored. It produces no done and no read, and its page is not cached.
- R10: After reset, done and mem_rd_req are low and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| dir_base | input | 32 | Page directory base; bits 31:12 are used |
| req_valid | input | 1 | Translation request strobe |
| req_laddr | input | 32 | Linear address to translate |
| done | output | 1 | One-cycle pulse, paddr valid |
| paddr | output | 32 | Translated physical address |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Memory read address |
| mem_rd_valid | input | 1 | Read data valid, completes the read |
| mem_rd_data | input | 32 | Read data |

## Verification
The bench builds the block with the default 32-entry cache. That makes it practical to fill every slot, so the invalid-slot fill order and the exact LRU victim after a touch can be checked deterministically. The memory model derives each directory and table entry arithmetically from its address and puts junk in the low 12 bits. Every read address and every result can therefore be predicted. The model's read latency is varied from 0 to 3 cycles, which covers reads that complete at once as well as long hold periods.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int VPN_W  = ADDR_W - OFF_W;
    localparam int PFN_W  = ADDR_W - OFF_W;

    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,
        WK_DIR  = 2'd1,
        WK_TBL  = 2'd2
    } wk_state_e;

    typedef struct packed {
        wk_state_e          st;
        logic [ADDR_W-1:0]  laddr;
        logic [PFN_W-1:0]   dfrm;
    } wk_st_t;

    typedef struct packed {
        logic               done;
        logic [ADDR_W-1:0]  paddr;
    } out_st_t;
endpackage

// File: rtl/pgx_tlb.sv
module pgx_tlb
    import pgx_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             lk_en,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn
);
    localparam int SEL_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [SEL_W-1:0] OLDEST = SEL_W'(ENTRIES - 1);

    typedef struct {
        logic [ENTRIES-1:0] valid;
        logic [VPN_W-1:0]   vpn [ENTRIES];
        logic [PFN_W-1:0]   pfn [ENTRIES];
        logic [SEL_W-1:0]   age [ENTRIES];
    } tlb_st_t;

    tlb_st_t st_q, st_d;

    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] oldest_vec;
    logic [SEL_W-1:0]   hit_idx, free_idx, oldest_idx, touch_idx;
    logic [PFN_W-1:0]   hit_pfn;
    logic               has_free, touch_en;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g]    = st_q.valid[g] && (st_q.vpn[g] == lk_vpn);
        assign oldest_vec[g] = (st_q.age[g] == OLDEST);
    end

    always_comb begin
        hit_idx    = '0;
        hit_pfn    = '0;
        free_idx   = '0;
        oldest_idx = '0;
        has_free   = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                hit_idx = SEL_W'(i);
                hit_pfn = hit_pfn | st_q.pfn[i];
            end
            if (oldest_vec[i]) oldest_idx = SEL_W'(i);
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!st_q.valid[i]) begin
                free_idx = SEL_W'(i);
                has_free = 1'b1;
            end
        end
    end

    assign lk_hit = (|hit_vec) && !flush;
    assign lk_pfn = hit_pfn;

    always_comb begin
        st_d      = st_q;
        touch_en  = 1'b0;
        touch_idx = '0;
        if (flush) begin
            st_d.valid = '0;
        end else if (lk_en && lk_hit) begin
            touch_en  = 1'b1;
            touch_idx = hit_idx;
        end else if (fill_en) begin
            touch_en  = 1'b1;
            touch_idx = has_free ? free_idx : oldest_idx;
            st_d.valid[touch_idx] = 1'b1;
            st_d.vpn[touch_idx]   = fill_vpn;
            st_d.pfn[touch_idx]   = fill_pfn;
        end
        if (touch_en) begin
            for (int j = 0; j < ENTRIES; j++) begin
                if (SEL_W'(j) == touch_idx) begin
                    st_d.age[j] = '0;
                end else if (st_q.age[j] < st_q.age[touch_idx]) begin
                    st_d.age[j] = st_q.age[j] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.valid <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                st_q.vpn[i] <= '0;
                st_q.pfn[i] <= '0;
                st_q.age[i] <= SEL_W'(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    // R4: a page lives in at most one slot
    p_hit_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    // R7: the use ordering always names exactly one oldest slot
    p_lru_unique_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1);
    // R8: a flush leaves no valid slot behind
    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.valid == '0));
endmodule

// File: rtl/pgx_walker.sv
module pgx_walker
    import pgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_laddr,
    input  logic [ADDR_W-1:0] dir_base,
    output logic              busy,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [ADDR_W-1:0] mem_rd_data,
    output logic              fill_en,
    output logic [VPN_W-1:0]  fill_vpn,
    output logic [PFN_W-1:0]  fill_pfn,
    output logic [OFF_W-1:0]  fill_off
);
    wk_st_t st_q, st_d;

    logic [IDX_W-1:0] dir_idx, tbl_idx;

    assign dir_idx = st_q.laddr[ADDR_W-1 -: IDX_W];
    assign tbl_idx = st_q.laddr[OFF_W +: IDX_W];

    assign busy        = (st_q.st != WK_IDLE);
    assign mem_rd_req  = busy;
    assign mem_rd_addr = (st_q.st == WK_DIR) ? {st_q.dfrm, dir_idx, 2'b00}
                                             : {mem_tfrm_q, tbl_idx, 2'b00};
    assign fill_en     = (st_q.st == WK_TBL) && mem_rd_valid;
    assign fill_vpn    = st_q.laddr[ADDR_W-1:OFF_W];
    assign fill_pfn    = mem_rd_data[ADDR_W-1:OFF_W];
    assign fill_off    = st_q.laddr[OFF_W-1:0];

    logic [PFN_W-1:0] mem_tfrm_q, mem_tfrm_d;

    always_comb begin
        st_d       = st_q;
        mem_tfrm_d = mem_tfrm_q;
        unique case (st_q.st)
            WK_IDLE: if (start) begin
                st_d.st    = WK_DIR;
                st_d.laddr = start_laddr;
                st_d.dfrm  = dir_base[ADDR_W-1:OFF_W];
            end
            WK_DIR: if (mem_rd_valid) begin
                st_d.st    = WK_TBL;
                mem_tfrm_d = mem_rd_data[ADDR_W-1:OFF_W];
            end
            WK_TBL: if (mem_rd_valid) st_d.st = WK_IDLE;
            default: st_d.st = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '{st: WK_IDLE, laddr: '0, dfrm: '0};
            mem_tfrm_q <= '0;
        end else begin
            st_q       <= st_d;
            mem_tfrm_q <= mem_tfrm_d;
        end
    end

    // R6: an unanswered read holds its request and address
    p_hold_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));
    // R1: entry addresses are word aligned
    p_word_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00));
endmodule

// File: rtl/pgx_top.sv
module pgx_top
    import pgx_pkg::*;
#(
    parameter int TLB_ENTRIES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic [31:0] dir_base,
    input  logic        req_valid,
    input  logic [31:0] req_laddr,
    output logic        done,
    output logic [31:0] paddr,
    output logic        mem_rd_req,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rd_valid,
    input  logic [31:0] mem_rd_data
);
    out_st_t out_q, out_d;

    logic             busy, lk_en, lk_hit, fill_en, start;
    logic [PFN_W-1:0] lk_pfn, fill_pfn;
    logic [VPN_W-1:0] fill_vpn;
    logic [OFF_W-1:0] fill_off;

    assign lk_en = req_valid && !busy;
    assign start = lk_en && !lk_hit;

    pgx_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .lk_en    (lk_en),
        .lk_vpn   (req_laddr[ADDR_W-1:OFF_W]),
        .lk_hit   (lk_hit),
        .lk_pfn   (lk_pfn),
        .fill_en  (fill_en),
        .fill_vpn (fill_vpn),
        .fill_pfn (fill_pfn)
    );

    pgx_walker u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .start_laddr  (req_laddr),
        .dir_base     (dir_base),
        .busy         (busy),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .fill_en      (fill_en),
        .fill_vpn     (fill_vpn),
        .fill_pfn     (fill_pfn),
        .fill_off     (fill_off)
    );

    always_comb begin
        out_d      = out_q;
        out_d.done = 1'b0;
        if (lk_en && lk_hit) begin
            out_d.done  = 1'b1;
            out_d.paddr = {lk_pfn, req_laddr[OFF_W-1:0]};
        end else if (fill_en) begin
            out_d.done  = 1'b1;
            out_d.paddr = {fill_pfn, fill_off};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{done: 1'b0, paddr: '0};
        else        out_q <= out_d;
    end

    assign done  = out_q.done;
    assign paddr = out_q.paddr;

    // R4: a hit answers next cycle without touching memory
    p_hit_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mem_rd_req && lk_hit) |=> (done && !mem_rd_req));
    // R5: no result while a read is outstanding
    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_rd_req);
endmodule

// File: tb/tb_pgx_top.sv
module tb_pgx_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] DBASE = 32'h0012_3ABC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_laddr = '0;
    logic        done;
    logic [31:0] paddr;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_data;

    int n_chk = 0, n_fail = 0;
    int lat_cfg = 0, wait_cnt = 0;
    int rd_cnt = 0, done_cnt = 0;
    logic [31:0] rd_a0, rd_a1;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgx_top dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .dir_base(DBASE),
        .req_valid(req_valid), .req_laddr(req_laddr), .done(done), .paddr(paddr),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    // memory model: bit 31 selects the table region
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (a[31]) return {20'(a[21:2] * 7 + 20'h00321), 12'h5A5};
        return {10'h200, a[11:2], 12'hFFF};
    endfunction

    assign mem_rd_valid = mem_rd_req && (wait_cnt >= lat_cfg);
    assign mem_rd_data  = mem_word(mem_rd_addr);

    always @(posedge clk) begin
        if (!mem_rd_req || mem_rd_valid) wait_cnt <= 0;
        else wait_cnt <= wait_cnt + 1;
        if (rst_n && mem_rd_req && mem_rd_valid) begin
            if (rd_cnt == 0) rd_a0 = mem_rd_addr;
            else if (rd_cnt == 1) rd_a1 = mem_rd_addr;
            rd_cnt = rd_cnt + 1;
        end
        if (rst_n && done) done_cnt = done_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] page(input int i);
        return {10'(i * 97 + 3), 10'(1023 - i * 13), 12'(i * 291)};
    endfunction

    task automatic xlat(input logic [31:0] la, input bit exp_hit, input string tag);
        logic [9:0] di, ti;
        logic [31:0] e_dir, e_tbl, e_pa;
        int cyc;
        di = la[31:22];
        ti = la[21:12];
        e_dir = {DBASE[31:12], 12'h000} + {20'h0, di, 2'b00};
        e_tbl = 32'h8000_0000 + {10'h0, di, 12'h000} + {20'h0, ti, 2'b00};
        e_pa  = {20'({di, ti} * 7 + 20'h00321), la[11:0]};
        rd_cnt = 0;
        req_valid = 1'b1;
        req_laddr = la;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, {tag, " done seen"}, 32'(done), 32'd1);
        chk(paddr == e_pa, {tag, " R3 paddr"}, paddr, e_pa);
        if (exp_hit) begin
            chk(cyc == 1, {tag, " R4 hit latency"}, 32'(cyc), 32'd1);
            chk(rd_cnt == 0, {tag, " R4 no reads on hit"}, 32'(rd_cnt), 32'd0);
        end else begin
            chk(rd_cnt == 2, {tag, " R5 two reads on miss"}, 32'(rd_cnt), 32'd2);
            chk(rd_a0 == e_dir, {tag, " R1 directory address"}, rd_a0, e_dir);
            chk(rd_a1 == e_tbl, {tag, " R2 table address"}, rd_a1, e_tbl);
        end
        @(negedge clk);
        chk(done == 1'b0, {tag, " R5 done is a pulse"}, 32'(done), 32'd0);
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R10 done low in reset", 32'(done), 32'd0);
        chk(mem_rd_req == 1'b0, "R10 no read in reset", 32'(mem_rd_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R10 done low after reset", 32'(done), 32'd0);
        chk(mem_rd_req == 1'b0, "R10 no read after reset", 32'(mem_rd_req), 32'd0);
        xlat(page(0), 1'b0, "R10 empty after reset");

        // fill every slot, latency swept 0..3
        do_flush();
        for (int i = 0; i < 32; i++) begin
            lat_cfg = i % 4;
            xlat(page(i), 1'b0, "R7 fill empty slot");
        end
        for (int i = 0; i < 32; i++) xlat(page(i), 1'b1, "R7 all slots kept");
        // page 0 used again; page 1 now oldest
        xlat(page(0), 1'b1, "R4 touch");
        xlat(page(32), 1'b0, "R7 evict oldest");
        xlat(page(0), 1'b1, "R7 recent kept");
        xlat(page(1), 1'b0, "R7 oldest evicted");
        xlat(page(2), 1'b0, "R7 next oldest evicted");
        xlat(page(32), 1'b1, "R7 new entry kept");

        // flush
        do_flush();
        xlat(page(0), 1'b0, "R8 miss after flush");
        flush = 1'b1;
        xlat(page(0), 1'b0, "R8 request with flush");
        flush = 1'b0;
        xlat(page(0), 1'b0, "R8 fill during flush dropped");
        xlat(page(0), 1'b1, "R8 refill kept");

        // ignored request during walk
        lat_cfg = 3;
        done_cnt = 0;
        rd_cnt = 0;
        req_valid = 1'b1;
        req_laddr = page(33);
        @(negedge clk);
        req_laddr = page(34);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        chk(done_cnt == 1, "R9 one done only", 32'(done_cnt), 32'd1);
        chk(rd_cnt == 2, "R9 no extra reads", 32'(rd_cnt), 32'd2);
        xlat(page(34), 1'b0, "R9 ignored page not cached");
        xlat(page(33), 1'b1, "R9 walked page cached");

        // corner addresses
        lat_cfg = 1;
        xlat(32'hFFFF_FFFF, 1'b0, "R1 top of space");
        xlat(32'h0000_0000, 1'b0, "R1 bottom of space");
        xlat(32'hFFFF_F000, 1'b1, "R4 same page other offset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule